// File: doc/BRIEF.md
# Pipelined Circular CORDIC Rotator and Vectorer

This block computes plane rotations and vector-to-polar conversions with shift-and-add arithmetic only. It accepts one sample per clock (`x_i`, `y_i`, `z_i` and an operation select `mode_i`) and returns the result of that sample a fixed number of cycles later. No input back-pressure exists. Bubbles in `valid_i` reappear as bubbles in `valid_o` at the same spacing.

The datapath is fully unrolled and has a register after every stage. A chain of `N_ROT` micro-rotation stages comes first. Stage `i` shifts by `i` and adds or subtracts a hard-wired arctangent constant. A chain of `N_SCALE` stages follows it. These stages cancel the CORDIC gain by adding signed, shifted copies of the rotated vector, so no multiplier is needed. The operation select travels with each sample, so rotation and vectoring samples can be mixed in one stream.

Angles are binary angles. The value 2^ANGLE_W stands for a full turn, so 16384 is +90 degrees when ANGLE_W is 16. With the default parameters the latency is 20 cycles.

Top module: `cordic_pipe`

## Requirements
- R1: `valid_o` is high exactly `N_ROT+N_SCALE` (default 20) clock cycles after each cycle in which `valid_i` was sampled high, and low in every other cycle.
- R2: The block accepts a new sample on every clock with no gaps. Results leave in the order the samples arrived, one result for each sample.
- R3: Rotation mode (`mode_i`=0), for |z_i| ≤ 2^(ANGLE_W-2): `x_o` is within 8 LSB of x·cos z − y·sin z, and `y_o` is within 8 LSB of x·sin z + y·cos z.
- R4: Rotation mode: the residual angle `z_o` is within 2 LSB of zero.
- R5: Vectoring mode (`mode_i`=1), for x_i ≥ 0: `x_o` is within 8 LSB of sqrt(x²+y²). `z_o` is within 3 LSB of z_i + atan2(y_i, x_i), compared modulo a full turn.
- R6: Vectoring mode: `y_o` is within 8 LSB of zero, and the x datapath never decreases or turns negative from one stage to the next.
- R7: `mode_o` equals the `mode_i` of the sample being output.
- R8: While `rst_ni` is low, `valid_o` is low. Samples presented during reset produce no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample valid |
| mode_i | input | 1 | 0 = rotate by z_i, 1 = vector (drive y to zero) |
| x_i | input | DATA_W | Signed x coordinate |
| y_i | input | DATA_W | Signed y coordinate |
| z_i | input | ANGLE_W | Binary angle (2^ANGLE_W = full turn) |
| valid_o | output | 1 | Result valid |
| mode_o | output | 1 | Mode of the result |
| x_o | output | DATA_W+1 | Signed x result, gain removed |
| y_o | output | DATA_W+1 | Signed y result, gain removed |
| z_o | output | ANGLE_W | Residual or accumulated angle |

## Verification
Every result is due 20 clock cycles after the rising edge that sampled its input. The bench records the cycle count when it drives each sample and queues the sample's expected values with the cycle number `count+20`. A monitor samples on the falling edge. It compares the queue head only in the cycle its due number comes up, and in every other cycle it requires `valid_o` to be low. A result that arrives early, late or out of order is therefore reported as a timing failure as well as a value failure.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  typedef enum logic {
    MODE_ROT = 1'b0,
    MODE_VEC = 1'b1
  } cordic_mode_e;

  localparam real PI_C = 3.14159265358979323846;

  // atan(2^-idx) in binary-angle units with frac_w bits per full turn
  function automatic longint atan_code(input int idx, input int frac_w);
    real t, x2, term, sum;
    if (idx == 0) begin
      sum = PI_C / 4.0;
    end else begin
      t = 1.0;
      for (int k = 0; k < idx; k++) t = t / 2.0;
      x2   = t * t;
      term = t;
      sum  = 0.0;
      for (int k = 0; k < 40; k++) begin
        if (k % 2 == 0) sum = sum + term / real'(2 * k + 1);
        else            sum = sum - term / real'(2 * k + 1);
        term = term * x2;
      end
    end
    return longint'($rtoi(sum * (2.0 ** frac_w) / (2.0 * PI_C) + 0.5));
  endfunction

endpackage

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage
  import cordic_pkg::*;
#(
  parameter int IW    = 22,
  parameter int ZW    = 20,
  parameter int SHIFT = 0,
  parameter logic signed [ZW-1:0] ANGLE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  cordic_mode_e         mode_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 valid_o,
  output cordic_mode_e         mode_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);

  logic                 dir_pos;
  logic signed [IW-1:0] x_sh, y_sh, x_nx, y_nx;
  logic signed [ZW-1:0] z_nx;

  // rotate: follow sign of z; vector: rotate toward x axis (-sign(x*y))
  always_comb begin
    dir_pos = (mode_i == MODE_VEC) ? (x_i[IW-1] ^ y_i[IW-1]) : ~z_i[ZW-1];
    x_sh    = x_i >>> SHIFT;
    y_sh    = y_i >>> SHIFT;
    x_nx    = dir_pos ? x_i - y_sh : x_i + y_sh;
    y_nx    = dir_pos ? y_i + x_sh : y_i - x_sh;
    z_nx    = dir_pos ? z_i - ANGLE : z_i + ANGLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= MODE_ROT;
      x_o     <= '0;
      y_o     <= '0;
      z_o     <= '0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      x_o     <= x_nx;
      y_o     <= y_nx;
      z_o     <= z_nx;
    end
  end

  // R6: in vectoring the x path only grows and stays non-negative
  p_vec_x_grows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == MODE_VEC && !x_i[IW-1]) |=> (!x_o[IW-1] && x_o >= $past(x_i)));

endmodule

// File: rtl/cordic_scale_stage.sv
module cordic_scale_stage
  import cordic_pkg::*;
#(
  parameter int   IW    = 22,
  parameter int   ZW    = 20,
  parameter int   SHIFT = 1,
  parameter logic NEG   = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  cordic_mode_e         mode_i,
  input  logic signed [IW-1:0] src_x_i,
  input  logic signed [IW-1:0] src_y_i,
  input  logic signed [IW-1:0] acc_x_i,
  input  logic signed [IW-1:0] acc_y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 valid_o,
  output cordic_mode_e         mode_o,
  output logic signed [IW-1:0] src_x_o,
  output logic signed [IW-1:0] src_y_o,
  output logic signed [IW-1:0] acc_x_o,
  output logic signed [IW-1:0] acc_y_o,
  output logic signed [ZW-1:0] z_o
);

  logic signed [IW-1:0] term_x, term_y;

  always_comb begin
    term_x = src_x_i >>> SHIFT;
    term_y = src_y_i >>> SHIFT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_o  <= MODE_ROT;
      src_x_o <= '0;
      src_y_o <= '0;
      acc_x_o <= '0;
      acc_y_o <= '0;
      z_o     <= '0;
    end else begin
      valid_o <= valid_i;
      mode_o  <= mode_i;
      src_x_o <= src_x_i;
      src_y_o <= src_y_i;
      acc_x_o <= NEG ? acc_x_i - term_x : acc_x_i + term_x;
      acc_y_o <= NEG ? acc_y_i - term_y : acc_y_i + term_y;
      z_o     <= z_i;
    end
  end

endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe
  import cordic_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ANGLE_W = 16,
  parameter int GUARD   = 4,
  parameter int N_ROT   = 16,
  parameter int N_SCALE = 4,
  parameter int unsigned SCALE_SHIFT [N_SCALE] = '{1, 3, 6, 9},
  parameter logic [N_SCALE-1:0] SCALE_NEG = 4'b1100
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic                      mode_i,
  input  logic signed [DATA_W-1:0]  x_i,
  input  logic signed [DATA_W-1:0]  y_i,
  input  logic signed [ANGLE_W-1:0] z_i,
  output logic                      valid_o,
  output logic                      mode_o,
  output logic signed [DATA_W:0]    x_o,
  output logic signed [DATA_W:0]    y_o,
  output logic signed [ANGLE_W-1:0] z_o
);

  localparam int IW    = DATA_W + 2 + GUARD;
  localparam int ZW    = ANGLE_W + GUARD;
  localparam int OW    = DATA_W + 1;
  localparam int LAT   = N_ROT + N_SCALE;
  localparam int CNT_W = $clog2(LAT + 2) + 1;
  localparam logic signed [IW-1:0] RND_XY = IW'(1) <<< (GUARD - 1);
  localparam logic signed [ZW-1:0] RND_Z  = ZW'(1) <<< (GUARD - 1);
  localparam int Z_TOL = 2 << GUARD;
  localparam int Y_TOL = (IW > N_ROT) ? (1 << (IW - N_ROT + 1)) : 2;

  // rotation chain
  logic                 rv [N_ROT+1];
  cordic_mode_e         rm [N_ROT+1];
  logic signed [IW-1:0] rx [N_ROT+1];
  logic signed [IW-1:0] ry [N_ROT+1];
  logic signed [ZW-1:0] rz [N_ROT+1];

  assign rv[0] = valid_i;
  assign rm[0] = cordic_mode_e'(mode_i);
  assign rx[0] = IW'(x_i) <<< GUARD;
  assign ry[0] = IW'(y_i) <<< GUARD;
  assign rz[0] = ZW'(z_i) <<< GUARD;

  for (genvar i = 0; i < N_ROT; i++) begin : g_rot
    cordic_rot_stage #(
      .IW   (IW),
      .ZW   (ZW),
      .SHIFT(i),
      .ANGLE(ZW'(atan_code(i, ZW)))
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(rv[i]),
      .mode_i (rm[i]),
      .x_i    (rx[i]),
      .y_i    (ry[i]),
      .z_i    (rz[i]),
      .valid_o(rv[i+1]),
      .mode_o (rm[i+1]),
      .x_o    (rx[i+1]),
      .y_o    (ry[i+1]),
      .z_o    (rz[i+1])
    );
  end

  // gain compensation chain: acc = sum of +/- (src >>> k)
  logic                 sv [N_SCALE+1];
  cordic_mode_e         sm [N_SCALE+1];
  logic signed [IW-1:0] sx [N_SCALE+1];
  logic signed [IW-1:0] sy [N_SCALE+1];
  logic signed [IW-1:0] ax [N_SCALE+1];
  logic signed [IW-1:0] ay [N_SCALE+1];
  logic signed [ZW-1:0] sz [N_SCALE+1];

  assign sv[0] = rv[N_ROT];
  assign sm[0] = rm[N_ROT];
  assign sx[0] = rx[N_ROT];
  assign sy[0] = ry[N_ROT];
  assign ax[0] = '0;
  assign ay[0] = '0;
  assign sz[0] = rz[N_ROT];

  for (genvar k = 0; k < N_SCALE; k++) begin : g_scale
    cordic_scale_stage #(
      .IW   (IW),
      .ZW   (ZW),
      .SHIFT(int'(SCALE_SHIFT[k])),
      .NEG  (SCALE_NEG[k])
    ) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .valid_i(sv[k]),
      .mode_i (sm[k]),
      .src_x_i(sx[k]),
      .src_y_i(sy[k]),
      .acc_x_i(ax[k]),
      .acc_y_i(ay[k]),
      .z_i    (sz[k]),
      .valid_o(sv[k+1]),
      .mode_o (sm[k+1]),
      .src_x_o(sx[k+1]),
      .src_y_o(sy[k+1]),
      .acc_x_o(ax[k+1]),
      .acc_y_o(ay[k+1]),
      .z_o    (sz[k+1])
    );
  end

  assign valid_o = sv[N_SCALE];
  assign mode_o  = sm[N_SCALE] == MODE_VEC;
  assign x_o     = OW'((ax[N_SCALE] + RND_XY) >>> GUARD);
  assign y_o     = OW'((ay[N_SCALE] + RND_XY) >>> GUARD);
  assign z_o     = ANGLE_W'((sz[N_SCALE] + RND_Z) >>> GUARD);

  // cycles since the last accepted sample, saturating above LAT
  logic [CNT_W-1:0] since_in_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_in_q <= CNT_W'(LAT + 1);
    else if (valid_i)                   since_in_q <= CNT_W'(1);
    else if (since_in_q <= CNT_W'(LAT)) since_in_q <= since_in_q + CNT_W'(1);
  end

  function automatic logic [IW:0] mag_xy(input logic signed [IW-1:0] v);
    return v[IW-1] ? (IW+1)'(-$signed({v[IW-1], v})) : (IW+1)'(v);
  endfunction

  function automatic logic [ZW:0] mag_z(input logic signed [ZW-1:0] v);
    return v[ZW-1] ? (ZW+1)'(-$signed({v[ZW-1], v})) : (ZW+1)'(v);
  endfunction

  p_valid_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> since_in_q <= CNT_W'(LAT));

  p_reset_quiet_r8: assert property (@(posedge clk_i)
    !rst_ni |-> !valid_o);

  p_z_conv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv[N_ROT] && rm[N_ROT] == MODE_ROT) |-> mag_z(rz[N_ROT]) <= (ZW+1)'(Z_TOL));

  p_y_conv_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rv[N_ROT] && rm[N_ROT] == MODE_VEC) |-> mag_xy(ry[N_ROT]) <= (IW+1)'(Y_TOL));

  p_gain_shrinks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (mag_xy(ax[N_SCALE]) <= mag_xy(sx[N_SCALE]) + (IW+1)'(N_SCALE)) &&
                (mag_xy(ay[N_SCALE]) <= mag_xy(sy[N_SCALE]) + (IW+1)'(N_SCALE)));

endmodule

// File: tb/tb_cordic_pipe.sv
`timescale 1ns/1ps
module tb_cordic_pipe;

  localparam int  LAT    = 20;
  localparam real TWO_PI = 6.28318530717958647692;
  localparam real TURN   = 65536.0;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               valid_i = 1'b0;
  logic               mode_i = 1'b0;
  logic signed [15:0] x_i = '0, y_i = '0, z_i = '0;
  logic               valid_o, mode_o;
  logic signed [16:0] x_o, y_o;
  logic signed [15:0] z_o;

  cordic_pipe dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .x_i(x_i), .y_i(y_i), .z_i(z_i),
    .valid_o(valid_o), .mode_o(mode_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  always #4 clk = ~clk;

  typedef struct {
    longint due;
    logic   mode;
    real    ex, ey, ez, ztol;
    bit     chk_z;
    string  tx, ty, tz;
  } exp_t;

  exp_t   q[$];
  int     checks = 0, errors = 0, sent = 0, got = 0;
  longint cyc = 0;
  bit     mon_en = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0.2f expected=%0.2f", req, what, act, exp_v);
    end
  endtask

  function automatic real wrap_turn(input real d);
    real r = d;
    while (r > TURN / 2.0)  r = r - TURN;
    while (r < -TURN / 2.0) r = r + TURN;
    return r;
  endfunction

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  // monitor: compare only in the cycle each result is due
  always @(negedge clk) begin
    exp_t e;
    real  dx, dy, dz;
    if (mon_en) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        got++;
        check(valid_o === 1'b1, "R1", "valid_o at due cycle", real'(valid_o), 1.0);
        check(mode_o === e.mode, "R7", "mode_o", real'(mode_o), real'(e.mode));
        dx = real'(x_o) - e.ex;
        dy = real'(y_o) - e.ey;
        check(absr(dx) <= 8.0, e.tx, "x_o", real'(x_o), e.ex);
        check(absr(dy) <= 8.0, e.ty, "y_o", real'(y_o), e.ey);
        if (e.chk_z) begin
          dz = wrap_turn(real'(z_o) - e.ez);
          check(absr(dz) <= e.ztol, e.tz, "z_o", real'(z_o), e.ez);
        end
      end else begin
        check(valid_o === 1'b0, "R1", "valid_o outside due cycle", real'(valid_o), 0.0);
      end
    end
  end

  task automatic push(input logic m, input int x, input int y, input int z, input bit cz);
    exp_t e;
    real  zr;
    zr = real'(z) * TWO_PI / TURN;
    @(negedge clk);
    valid_i = 1'b1;
    mode_i  = m;
    x_i     = 16'(x);
    y_i     = 16'(y);
    z_i     = 16'(z);
    e.due   = cyc + LAT;
    e.mode  = m;
    e.chk_z = cz;
    if (!m) begin
      e.ex = real'(x) * $cos(zr) - real'(y) * $sin(zr);
      e.ey = real'(x) * $sin(zr) + real'(y) * $cos(zr);
      e.ez = 0.0; e.ztol = 2.0;
      e.tx = "R3"; e.ty = "R3"; e.tz = "R4";
    end else begin
      e.ex = $sqrt(real'(x) * real'(x) + real'(y) * real'(y));
      e.ey = 0.0;
      e.ez = real'(z) + $atan2(real'(y), real'(x)) * TURN / TWO_PI;
      e.ztol = 3.0;
      e.tx = "R5"; e.ty = "R6"; e.tz = "R5";
    end
    q.push_back(e);
    sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  task automatic drain_and_count(input int got0, input int n, input string what);
    idle(LAT + 3);
    check(got - got0 == n, "R2", what, real'(got - got0), real'(n));
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom_range(hi - lo, 0));
  endfunction

  // R8: reset holds valid_o low and drops samples offered in reset
  task automatic t_reset;
    rst_n   = 1'b0;
    valid_i = 1'b1;
    x_i     = 16'sd1000;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(valid_o === 1'b0, "R8", "valid_o in reset", real'(valid_o), 0.0);
    end
    valid_i = 1'b0;
    rst_n   = 1'b1;
    mon_en  = 1'b1;
    idle(LAT + 3);
  endtask

  // R2, R3, R4: back-to-back rotations
  task automatic t_rotate_burst;
    int g0 = got;
    for (int i = 0; i < 64; i++)
      push(1'b0, rnd(-8191, 8191), rnd(-8191, 8191), rnd(-16384, 16384), 1'b1);
    drain_and_count(g0, 64, "rotation burst count");
  endtask

  // R2, R5, R6: back-to-back vectoring
  task automatic t_vector_burst;
    int g0 = got;
    for (int i = 0; i < 64; i++)
      push(1'b1, rnd(1000, 8191), rnd(-8191, 8191), rnd(-32768, 32767), 1'b1);
    drain_and_count(g0, 64, "vectoring burst count");
  endtask

  // R1, R7: mixed modes with random bubbles
  task automatic t_mixed_gaps;
    int g0 = got;
    for (int i = 0; i < 48; i++) begin
      idle(rnd(0, 2));
      if (rnd(0, 1) == 1) push(1'b1, rnd(1000, 8191), rnd(-8191, 8191), rnd(-32768, 32767), 1'b1);
      else                push(1'b0, rnd(-8191, 8191), rnd(-8191, 8191), rnd(-16384, 16384), 1'b1);
    end
    drain_and_count(g0, 48, "mixed stream count");
  endtask

  // R3..R6 boundary cases
  task automatic t_corners;
    int g0 = got;
    push(1'b0,  8191,     0,      0, 1'b1);   // R3 zero angle: gain removed
    push(1'b0,  8191,     0,  16384, 1'b1);   // R3 +90 degrees
    push(1'b0,  8191,     0, -16384, 1'b1);   // R3 -90 degrees
    push(1'b0, -8191,  8191,  16384, 1'b1);   // R3 R4 both components
    push(1'b0,     0,     0,   5000, 1'b1);   // R3 zero vector
    push(1'b1,  8191,     0,      0, 1'b1);   // R5 on axis
    push(1'b1,  5000, -5000,    100, 1'b1);   // R5 R6 -45 degrees
    push(1'b1,     1,  8191,      0, 1'b1);   // R5 near +90 degrees
    push(1'b1,  6000,  6000,  32000, 1'b1);   // R5 angle wraps past half turn
    push(1'b1,     0,     0,      0, 1'b0);   // R6 zero vector
    drain_and_count(g0, 10, "corner count");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    t_reset();
    t_rotate_burst();
    t_vector_burst();
    t_mixed_gaps();
    t_corners();
    check(q.size() == 0, "R1", "results left pending", real'(q.size()), 0.0);
    check(got == sent, "R2", "total results", real'(got), real'(sent));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule